// File: doc/BRIEF.md
# Mesh Sweep Output Sequencer

This block controls a vertex-mesh processor. Software sets a base address and the last column and last row of a 2-D grid of points, then writes the start bit. The block visits every (x, y) point with the row index in the outer loop and the column index in the inner loop. For each point it presents the two coordinates to an external microcode engine, so that the engine can load them into its first two general registers and restart its program at address zero. It then lets the engine run until the engine signals a vector-output instruction.

On a vector output the block takes the engine's two operand words and computes the point's output address. The row pitch is fixed at 128 points and each point owns an 8-byte slot. It then issues two 32-bit write requests, byte-swapped to big-endian order, through a request/acknowledge port. A point whose program executes 2048 instructions without an output is abandoned: a sticky error bit is set and the sweep continues. After the last point the block stores the vertex count and raises a one-cycle interrupt.

Top module: `mesh_sweep_seq`

## Requirements
- R1: After reset every register reads 0. Writing a 1 in bit 0 to register offset 0 while idle starts a sweep. Bit 0 of offset 0 reads 1 while a sweep is in progress and 0 otherwise.
- R2: Points are visited with y running from 0 to the last-row register (offset 3) and x from 0 to the last-column register (offset 2), both inclusive, with x changing fastest. Each point begins with a one-cycle `eng_load` pulse carrying x on `eng_x` and y on `eng_y`.
- R3: The first output word of a point goes to base + 8*(128*y + x), where base is register offset 1. The second word goes to that address plus 4.
- R4: Output words are big-endian: bits [7:0] of an operand appear on `mem_data[31:24]`, bits [15:8] on [23:16], bits [23:16] on [15:8] and bits [31:24] on [7:0]. `eng_opa` is written first and `eng_opb` second.
- R5: Register offset 5 holds the address of the second word of the most recent completed output.
- R6: A write request holds its address and data until it is acknowledged. The next point's `eng_load` never occurs while a write is outstanding.
- R7: A point that takes 2048 engine steps without a vector output is abandoned. No write is issued for it, bit 1 of offset 0 becomes 1, and the sweep goes on to the next point. A point that takes 2047 steps and then a vector output is written normally. Bit 1 is cleared when a sweep starts.
- R8: At the end of a sweep, offset 4 holds (last column + 1) * (last row + 1), and `irq` is high for exactly one cycle, once per sweep.
- R9: A start write that arrives while a sweep is busy is ignored. It neither restarts nor extends the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| eng_load | output | 1 | Point start: load coordinates, restart program at 0 |
| eng_x | output | 32 | Column coordinate for general register 0 |
| eng_y | output | 32 | Row coordinate for general register 1 |
| eng_run | output | 1 | Engine may execute instructions |
| eng_step | input | 1 | Engine executed one non-output instruction |
| eng_vout | input | 1 | Engine reached the vector-output instruction |
| eng_opa | input | 32 | First output operand |
| eng_opb | input | 32 | Second output operand |
| mem_req | output | 1 | Write request valid |
| mem_addr | output | 32 | Write byte address |
| mem_data | output | 32 | Write data |
| mem_ack | input | 1 | Write acknowledged |
| irq | output | 1 | End-of-sweep pulse |

## Verification
The bench targets the watchdog boundary by running one point at 2047 steps and one at 2048 steps. A design that is off by one either writes a point it should drop or drops a point it should write. A second row at non-zero y exposes a pitch taken from the mesh width instead of the fixed 128. Distinct bytes in every operand expose a missing or partial byte swap. A slow acknowledge shows whether the block starts the next point, or moves the address, while a write is still pending. A second start issued mid-sweep would show up as extra coordinate loads or a second interrupt.

// File: rtl/mesh_sweep_pkg.sv
package mesh_sweep_pkg;

    localparam int WORD_W     = 32;
    localparam int REG_AW     = 3;
    localparam int ROW_SHIFT  = 7;   // 128 points per row, fixed
    localparam int SLOT_SHIFT = 3;   // 8 bytes per point

    localparam logic [REG_AW-1:0] RA_CTRL    = 3'd0;
    localparam logic [REG_AW-1:0] RA_BASE    = 3'd1;
    localparam logic [REG_AW-1:0] RA_LASTCOL = 3'd2;
    localparam logic [REG_AW-1:0] RA_LASTROW = 3'd3;
    localparam logic [REG_AW-1:0] RA_VCOUNT  = 3'd4;
    localparam logic [REG_AW-1:0] RA_LASTOUT = 3'd5;

    typedef enum logic [2:0] {
        SW_IDLE,
        SW_LOAD,
        SW_RUN,
        SW_WRITE,
        SW_NEXT,
        SW_DONE
    } sweep_state_e;

    typedef enum logic [1:0] {
        WP_IDLE,
        WP_FIRST,
        WP_SECOND
    } wport_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
    } out_pair_t;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [WORD_W-1:0] point_addr(input logic [WORD_W-1:0] base,
                                                     input logic [WORD_W-1:0] x,
                                                     input logic [WORD_W-1:0] y);
        return base + (((y << ROW_SHIFT) + x) << SLOT_SHIFT);
    endfunction

endpackage

// File: rtl/mesh_grid_walker.sv
module mesh_grid_walker #(
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               advance,
    input  logic [COORD_W-1:0] last_x,
    input  logic [COORD_W-1:0] last_y,
    output logic [COORD_W-1:0] x,
    output logic [COORD_W-1:0] y,
    output logic               at_grid_end
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            x <= '0;
            y <= '0;
        end else if (advance) begin
            if (x == last_x) begin
                x <= '0;
                y <= y + COORD_W'(1);
            end else begin
                x <= x + COORD_W'(1);
            end
        end
    end

    assign at_grid_end = (x == last_x) && (y == last_y);

    // R2: column advances within a row, row held
    p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear && x != last_x) |=> (x == $past(x) + COORD_W'(1)) && $stable(y));

    // R2: end of row wraps column and moves to next row
    p_row_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear && x == last_x) |=> (x == '0) && (y == $past(y) + COORD_W'(1)));

endmodule

// File: rtl/mesh_point_wdog.sv
module mesh_point_wdog #(
    parameter int LIMIT = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic expire
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + CW'(1);
        end
    end

    // the step that would be number LIMIT ends the point
    assign expire = step && (cnt == CW'(LIMIT - 1));

    // R7: a cleared counter cannot expire on the very next step
    p_fresh_no_expire_r7: assert property (@(posedge clk) disable iff (rst)
        clear |=> !expire);

endmodule

// File: rtl/mesh_pair_writer.sv
module mesh_pair_writer
    import mesh_sweep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  out_pair_t         pair_in,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    input  logic              mem_ack,
    output logic              done
);

    wport_state_e st_q;
    out_pair_t    pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WP_IDLE;
            pair_q <= '0;
        end else begin
            case (st_q)
                WP_IDLE: begin
                    if (start) begin
                        pair_q <= pair_in;
                        st_q   <= WP_FIRST;
                    end
                end
                WP_FIRST: begin
                    if (mem_ack) st_q <= WP_SECOND;
                end
                WP_SECOND: begin
                    if (mem_ack) st_q <= WP_IDLE;
                end
                default: st_q <= WP_IDLE;
            endcase
        end
    end

    assign mem_req  = (st_q != WP_IDLE);
    assign mem_addr = (st_q == WP_SECOND) ? pair_q.addr + WORD_W'(4) : pair_q.addr;
    assign mem_data = (st_q == WP_SECOND) ? pair_q.w1 : pair_q.w0;
    assign done     = (st_q == WP_SECOND) && mem_ack;

    // R6: an unacknowledged request keeps address and data
    p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_data));

    // R3: second word follows the first at +4
    p_second_word_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == WP_FIRST && mem_ack) |=> mem_req && (mem_addr == $past(mem_addr) + WORD_W'(4)));

endmodule

// File: rtl/mesh_sweep_seq.sv
module mesh_sweep_seq
    import mesh_sweep_pkg::*;
#(
    parameter int COORD_W    = 16,
    parameter int WDOG_LIMIT = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [2:0]        reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    output logic              eng_load,
    output logic [31:0]       eng_x,
    output logic [31:0]       eng_y,
    output logic              eng_run,
    input  logic              eng_step,
    input  logic              eng_vout,
    input  logic [31:0]       eng_opa,
    input  logic [31:0]       eng_opb,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_data,
    input  logic              mem_ack,
    output logic              irq
);

    localparam int PROD_W = 64;

    sweep_state_e       st_q;
    logic [WORD_W-1:0]  base_q;
    logic [WORD_W-1:0]  last_out_q;
    logic [WORD_W-1:0]  vcount_q;
    logic [COORD_W-1:0] lastc_q;
    logic [COORD_W-1:0] lastr_q;
    logic               err_q;
    logic [WORD_W-1:0]  pair_addr_q;

    logic [COORD_W-1:0] px;
    logic [COORD_W-1:0] py;
    logic               at_grid_end;
    logic               start_req;
    logic               walk_clear;
    logic               walk_adv;
    logic               wd_clear;
    logic               wd_step;
    logic               wd_expire;
    logic               wr_start;
    logic               wr_done;
    out_pair_t          pair_now;
    logic [PROD_W-1:0]  prod_full;

    assign start_req = reg_wr_en && (reg_wr_addr == RA_CTRL) && reg_wr_data[0];

    assign walk_clear = (st_q == SW_IDLE) && start_req;
    assign walk_adv   = (st_q == SW_NEXT) && !at_grid_end;
    assign wd_clear   = (st_q == SW_LOAD);
    assign wd_step    = (st_q == SW_RUN) && eng_step && !eng_vout;
    assign wr_start   = (st_q == SW_RUN) && eng_vout;

    always_comb begin
        pair_now.addr = point_addr(base_q, WORD_W'(px), WORD_W'(py));
        pair_now.w0   = swap_bytes(eng_opa);
        pair_now.w1   = swap_bytes(eng_opb);
    end

    assign prod_full = PROD_W'(lastc_q) * PROD_W'(lastr_q) + PROD_W'(lastc_q)
                     + PROD_W'(lastr_q) + PROD_W'(1);

    mesh_grid_walker #(.COORD_W(COORD_W)) u_walker (
        .clk         (clk),
        .rst         (rst),
        .clear       (walk_clear),
        .advance     (walk_adv),
        .last_x      (lastc_q),
        .last_y      (lastr_q),
        .x           (px),
        .y           (py),
        .at_grid_end (at_grid_end)
    );

    mesh_point_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .clear  (wd_clear),
        .step   (wd_step),
        .expire (wd_expire)
    );

    mesh_pair_writer u_writer (
        .clk      (clk),
        .rst      (rst),
        .start    (wr_start),
        .pair_in  (pair_now),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .mem_ack  (mem_ack),
        .done     (wr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= SW_IDLE;
            base_q      <= '0;
            last_out_q  <= '0;
            vcount_q    <= '0;
            lastc_q     <= '0;
            lastr_q     <= '0;
            err_q       <= 1'b0;
            pair_addr_q <= '0;
        end else begin
            if (reg_wr_en) begin
                case (reg_wr_addr)
                    RA_BASE:    base_q  <= reg_wr_data;
                    RA_LASTCOL: lastc_q <= reg_wr_data[COORD_W-1:0];
                    RA_LASTROW: lastr_q <= reg_wr_data[COORD_W-1:0];
                    default: ;
                endcase
            end
            case (st_q)
                SW_IDLE: begin
                    if (start_req) begin
                        err_q <= 1'b0;
                        st_q  <= SW_LOAD;
                    end
                end
                SW_LOAD: st_q <= SW_RUN;
                SW_RUN: begin
                    if (eng_vout) begin
                        pair_addr_q <= pair_now.addr;
                        st_q        <= SW_WRITE;
                    end else if (wd_expire) begin
                        err_q <= 1'b1;
                        st_q  <= SW_NEXT;
                    end
                end
                SW_WRITE: begin
                    if (wr_done) begin
                        last_out_q <= pair_addr_q + WORD_W'(4);
                        st_q       <= SW_NEXT;
                    end
                end
                SW_NEXT: begin
                    if (at_grid_end) begin
                        vcount_q <= prod_full[WORD_W-1:0];
                        st_q     <= SW_DONE;
                    end else begin
                        st_q <= SW_LOAD;
                    end
                end
                SW_DONE: st_q <= SW_IDLE;
                default: st_q <= SW_IDLE;
            endcase
        end
    end

    always_comb begin
        case (reg_rd_addr)
            RA_CTRL:    reg_rd_data = {30'd0, err_q, (st_q != SW_IDLE)};
            RA_BASE:    reg_rd_data = base_q;
            RA_LASTCOL: reg_rd_data = WORD_W'(lastc_q);
            RA_LASTROW: reg_rd_data = WORD_W'(lastr_q);
            RA_VCOUNT:  reg_rd_data = vcount_q;
            RA_LASTOUT: reg_rd_data = last_out_q;
            default:    reg_rd_data = '0;
        endcase
    end

    assign eng_load = (st_q == SW_LOAD);
    assign eng_x    = WORD_W'(px);
    assign eng_y    = WORD_W'(py);
    assign eng_run  = (st_q == SW_RUN);
    assign irq      = (st_q == SW_DONE);

    // R1: an accepted start leads straight to a coordinate load
    p_start_load_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == SW_IDLE && start_req) |=> eng_load);

    // R6: no new point while a write is pending
    p_no_load_in_write_r6: assert property (@(posedge clk) disable iff (rst)
        eng_load |-> !mem_req);

    // R7: an abandoned point issues no write and stops the engine
    p_abandon_r7: assert property (@(posedge clk) disable iff (rst)
        (eng_run && !eng_vout && wd_expire) |=> !mem_req && !eng_run);

    // R8: interrupt is a single-cycle pulse
    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R9: a start while busy leaves the sweep running
    p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q != SW_IDLE && st_q != SW_DONE && start_req) |=> (st_q != SW_IDLE));

endmodule

// File: tb/tb_mesh_sweep_seq.sv
module tb_mesh_sweep_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [2:0]  reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic [2:0]  reg_rd_addr;
    logic [31:0] reg_rd_data;
    logic        eng_load;
    logic [31:0] eng_x;
    logic [31:0] eng_y;
    logic        eng_run;
    logic        eng_step;
    logic        eng_vout;
    logic [31:0] eng_opa;
    logic [31:0] eng_opb;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_ack;
    logic        irq;

    always #2 clk = ~clk;   // 250 MHz

    mesh_sweep_seq dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .eng_load(eng_load), .eng_x(eng_x), .eng_y(eng_y), .eng_run(eng_run),
        .eng_step(eng_step), .eng_vout(eng_vout), .eng_opa(eng_opa), .eng_opb(eng_opb),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    // scenario configuration used by the models
    int steps_cfg = 0;
    int ack_dly_cfg = 0;

    // logs
    logic [31:0] wa [0:255];
    logic [31:0] wd [0:255];
    logic [31:0] lx [0:255];
    logic [31:0] ly [0:255];
    int wcnt = 0;
    int lcnt = 0;
    int irq_cnt = 0;
    int irq_run = 0;
    int irq_max = 0;
    int load_overlap = 0;

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction
    function automatic logic [31:0] opa_of(input logic [31:0] x, input logic [31:0] y);
        return {x[7:0], 8'h11, y[7:0], 8'h22};
    endfunction
    function automatic logic [31:0] opb_of(input logic [31:0] x, input logic [31:0] y);
        return {8'hA5, y[7:0], 8'h3C, x[7:0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // engine model
    int cnt_left = 0;
    bit pending = 0;
    logic [31:0] cur_x = 0;
    logic [31:0] cur_y = 0;
    initial begin
        eng_step = 0; eng_vout = 0; eng_opa = 0; eng_opb = 0;
        forever begin
            @(negedge clk);
            eng_step = 0; eng_vout = 0;
            if (eng_load) begin
                cur_x = eng_x; cur_y = eng_y;
                lx[lcnt[7:0]] = eng_x; ly[lcnt[7:0]] = eng_y;
                lcnt++;
                if (mem_req) load_overlap++;
                cnt_left = steps_cfg;
                pending = 1;
            end else if (pending && eng_run) begin
                if (cnt_left > 0) begin
                    eng_step = 1;
                    cnt_left--;
                end else begin
                    eng_vout = 1;
                    eng_opa = opa_of(cur_x, cur_y);
                    eng_opb = opb_of(cur_x, cur_y);
                    pending = 0;
                end
            end
        end
    end

    // memory model
    int dly = 0;
    initial begin
        mem_ack = 0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                if (dly <= 0) begin
                    mem_ack = 1;
                    wa[wcnt[7:0]] = mem_addr;
                    wd[wcnt[7:0]] = mem_data;
                    wcnt++;
                end else begin
                    dly--;
                end
            end else begin
                mem_ack = 0;
                dly = ack_dly_cfg;
            end
        end
    end

    // interrupt monitor
    initial begin
        forever begin
            @(negedge clk);
            if (irq) begin
                irq_cnt++;
                irq_run++;
                if (irq_run > irq_max) irq_max = irq_run;
            end else begin
                irq_run = 0;
            end
        end
    end

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL all watchdog actual=running expected=finished");
        summary_and_end();
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_rd_addr = a;
        #0.5;
        v = reg_rd_data;
    endtask

    task automatic clear_logs();
        wcnt = 0; lcnt = 0; load_overlap = 0; irq_max = 0;
    endtask

    task automatic wait_done(input int irq_before);
        int t = 0;
        while (irq_cnt == irq_before && t < 30000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic configure(input logic [31:0] base, input int lc, input int lr, input int steps, input int adly);
        steps_cfg = steps; ack_dly_cfg = adly;
        wr(3'd1, base);
        wr(3'd2, lc);
        wr(3'd3, lr);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1", "ctrl after reset", v, 0);
        rd(3'd4, v); chk("R1", "vertex count after reset", v, 0);
        rd(3'd5, v); chk("R1", "last out after reset", v, 0);
        chk("R1", "no request after reset", {31'd0, mem_req}, 0);
    endtask

    task automatic test_grid();
        logic [31:0] v;
        logic [31:0] base = 32'h1000_0000;
        int ib, p;
        configure(base, 2, 1, 3, 0);
        clear_logs();
        ib = irq_cnt;
        wr(3'd0, 1);
        rd(3'd0, v); chk("R1", "busy bit during sweep", v & 1, 1);
        wait_done(ib);
        chk("R2", "load count", lcnt, 6);
        p = 0;
        for (int y = 0; y <= 1; y++) begin
            for (int x = 0; x <= 2; x++) begin
                logic [31:0] a;
                chk("R2", "load x", lx[p], x);
                chk("R2", "load y", ly[p], y);
                a = base + 8 * (128 * y + x);
                chk("R3", "first addr", wa[2*p], a);
                chk("R3", "second addr", wa[2*p+1], a + 4);
                chk("R4", "first word", wd[2*p], bswap(opa_of(x, y)));
                chk("R4", "second word", wd[2*p+1], bswap(opb_of(x, y)));
                p++;
            end
        end
        chk("R3", "write count", wcnt, 12);
        rd(3'd5, v); chk("R5", "last out addr", v, base + 8 * (128 + 2) + 4);
        rd(3'd4, v); chk("R8", "vertex count", v, 6);
        chk("R8", "one irq", irq_cnt - ib, 1);
        chk("R8", "irq width", irq_max, 1);
        rd(3'd0, v); chk("R1", "idle after sweep", v & 1, 0);
    endtask

    task automatic test_slow_ack();
        logic [31:0] v;
        int ib;
        configure(32'h0000_0040, 1, 0, 0, 3);
        clear_logs();
        ib = irq_cnt;
        wr(3'd0, 1);
        wait_done(ib);
        chk("R6", "write count slow ack", wcnt, 4);
        chk("R6", "first addr slow ack", wa[0], 32'h40);
        chk("R6", "second addr slow ack", wa[1], 32'h44);
        chk("R6", "third addr slow ack", wa[2], 32'h48);
        chk("R6", "load during write", load_overlap, 0);
        rd(3'd5, v); chk("R5", "last out slow ack", v, 32'h4C);
        rd(3'd4, v); chk("R8", "vertex count 2x1", v, 2);
    endtask

    task automatic test_watchdog();
        logic [31:0] v;
        int ib;
        configure(32'h0000_8000, 1, 0, 2048, 0);
        clear_logs();
        ib = irq_cnt;
        wr(3'd0, 1);
        wait_done(ib);
        chk("R7", "no writes on abandon", wcnt, 0);
        chk("R7", "both points loaded", lcnt, 2);
        rd(3'd0, v); chk("R7", "error bit set", v & 3, 2);
        rd(3'd4, v); chk("R8", "vertex count after abandon", v, 2);
        configure(32'h0000_8000, 0, 0, 2047, 0);
        clear_logs();
        ib = irq_cnt;
        wr(3'd0, 1);
        wait_done(ib);
        chk("R7", "2047 steps written", wcnt, 2);
        chk("R7", "2047 steps addr", wa[0], 32'h8000);
        rd(3'd0, v); chk("R7", "error bit cleared", v & 3, 0);
    endtask

    task automatic test_busy_start();
        logic [31:0] v;
        int ib;
        configure(32'h0002_0000, 1, 1, 5, 1);
        clear_logs();
        ib = irq_cnt;
        wr(3'd0, 1);
        repeat (6) @(negedge clk);
        wr(3'd0, 1);
        wait_done(ib);
        repeat (40) @(negedge clk);
        chk("R9", "loads unchanged", lcnt, 4);
        chk("R9", "single irq", irq_cnt - ib, 1);
        chk("R9", "writes", wcnt, 8);
        rd(3'd4, v); chk("R8", "vertex count 2x2", v, 4);
    endtask

    initial begin
        rst = 1; reg_wr_en = 0; reg_wr_addr = 0; reg_wr_data = 0; reg_rd_addr = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset();
        test_grid();
        test_slow_ack();
        test_watchdog();
        test_busy_start();
        summary_and_end();
    end

endmodule